// File: doc/BRIEF.md
# Four-Page Bank Mapper with Boot Overlay

The block sits between an 8-bit processor that sees a 64K address space and an 18-bit physical memory bus. The processor's two highest address bits choose one of four 16K pages. Each page has a 4-bit bank number held in a small register table. That bank number becomes the four top physical address bits, placed above the 14 untouched offset bits. Banks 0 to 7 are RAM and banks 8 to 15 are ROM, split by the top physical bit. A second control flag steers every ROM-mapped access to one of two ROM devices.

Software loads the table with single control-byte writes through one I/O port. The block receives that port as a ready-made strobe that already includes the write qualifier. The table has no reset and holds unknown values after power-up. Instead, a boot flag is set by the asynchronous reset. While the boot flag is set, every page reads as bank 15, so boot code runs from the top 16K of the physical space. The table can be filled during boot. A write with the boot bit clear stores its entry and leaves boot mode on the same strobe.

Control byte: bit 7 is the boot flag, bit 6 is the ROM device choice, bits 5:4 are the page number, and bits 3:0 are the bank number.

Top module: `pagemap_mmu`

## Requirements
- R1: After reset the boot flag is 1, so physical address bits 17:14 read 1111 for every page and bits 13:0 equal CPU address bits 13:0.
- R2: While the boot flag is 1, table writes are stored but do not change the physical address, which stays at 1111 on bits 17:14.
- R3: A strobed write with bit 7 = 0 stores bank bits 3:0 into the page given by bits 5:4 and leaves boot mode on that same strobe. The new entry drives the address from the next cycle.
- R4: Outside boot mode, physical address = {entry[A15:A14], A13:A0}.
- R5: Without the port strobe, the data byte has no effect, and the mapping and chip selects stay unchanged.
- R6: A strobed write with bit 7 = 1 re-enters boot mode, and bits 17:14 return to 1111 from the next cycle.
- R7: The RAM enable is active high and is 1 only when the memory request is 1 and physical bit 17 = 0.
- R8: The ROM device flag is set by reset and loaded from bit 6 on every strobe. When the memory request is 1 and physical bit 17 = 1, the active-low ROM A select is 0 if the flag = 1, and the ROM B select is 0 if the flag = 0. Both selects are 1 otherwise.
- R9: Reset is asynchronous and active low. It sets the boot flag and the ROM flag without waiting for a clock edge.
- R10: A table write changes only the addressed page's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table and flags |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Control byte on the CPU data bus |
| port_wr | input | 1 | Decoded port write strobe, sampled on the rising edge |
| mem_req | input | 1 | CPU memory request, active high |
| phys_addr | output | 18 | Physical memory address |
| ram_ce | output | 1 | RAM enable, active high |
| rom_a_cs_n | output | 1 | ROM A select, active low |
| rom_b_cs_n | output | 1 | ROM B select, active low |

## Verification
The table load and the boot-flag change happen on the same strobe. When a write has bit 7 clear, the entry update and the exit from boot mode land in the same cycle. The bench provokes this by filling three pages while in boot mode, then writing the fourth with bit 7 clear. It checks on the following cycle that all four pages, including the one just written, show their new banks. The reverse case is also covered: a write with bit 7 set stores a new entry while hiding it behind the forced top bank. That entry is then checked once a later exit write exposes it.

// File: rtl/pagemap_mmu.sv
module pagemap_mmu #(
  parameter int OFS_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFS_W+1:0]     cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 port_wr,
  input  logic                 mem_req,
  output logic [OFS_W+3:0]     phys_addr,
  output logic                 ram_ce,
  output logic                 rom_a_cs_n,
  output logic                 rom_b_cs_n
);
  localparam int BANK_W = 4;
  localparam int PSEL_W = 2;
  localparam int PAGES  = 1 << PSEL_W;
  localparam int CPU_AW = OFS_W + PSEL_W;

  logic                           boot_q;
  logic                           rom_pick_q;
  logic [PAGES-1:0][BANK_W-1:0]   tbl;
  logic [BANK_W-1:0]              sel_bank;
  logic [BANK_W-1:0]              hi_bits;
  logic                           rom_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      boot_q     <= 1'b1;
      rom_pick_q <= 1'b1;
    end else if (port_wr) begin
      boot_q     <= cpu_wdata[7];
      rom_pick_q <= cpu_wdata[6];
    end

  always_ff @(posedge clk)
    for (int p = 0; p < PAGES; p++)
      if (port_wr && cpu_wdata[5:4] == PSEL_W'(p))
        tbl[p] <= cpu_wdata[BANK_W-1:0];

  assign sel_bank  = tbl[cpu_addr[CPU_AW-1:OFS_W]];
  assign hi_bits   = boot_q ? {BANK_W{1'b1}} : sel_bank;
  assign phys_addr = {hi_bits, cpu_addr[OFS_W-1:0]};

  assign rom_hit    = mem_req & hi_bits[BANK_W-1];
  assign ram_ce     = mem_req & ~hi_bits[BANK_W-1];
  assign rom_a_cs_n = ~(rom_hit & rom_pick_q);
  assign rom_b_cs_n = ~(rom_hit & ~rom_pick_q);
endmodule

// File: rtl/pagemap_mmu_chk.sv
module pagemap_mmu_chk #(
  parameter int OFS_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W+1:0] cpu_addr,
  input logic [7:0]       cpu_wdata,
  input logic             port_wr,
  input logic             mem_req,
  input logic [OFS_W+3:0] phys_addr,
  input logic             ram_ce,
  input logic             rom_a_cs_n,
  input logic             rom_b_cs_n
);
  AST_BOOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr && cpu_wdata[7] |=> &phys_addr[OFS_W+3:OFS_W]); // R6

  AST_WRITE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr && !cpu_wdata[7] ##1 (cpu_addr[OFS_W+1:OFS_W] == $past(cpu_wdata[5:4]))
    |-> phys_addr[OFS_W+3:OFS_W] == $past(cpu_wdata[3:0])); // R3

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr ##1 $stable(cpu_addr) |-> $stable(phys_addr)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !ram_ce && rom_a_cs_n && rom_b_cs_n); // R7

  AST_RAM_ROM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_ce, ~rom_a_cs_n, ~rom_b_cs_n}) <= 1); // R8

  AST_RAM_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> !phys_addr[OFS_W+3]); // R7
endmodule

bind pagemap_mmu pagemap_mmu_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .port_wr(port_wr), .mem_req(mem_req), .phys_addr(phys_addr),
  .ram_ce(ram_ce), .rom_a_cs_n(rom_a_cs_n), .rom_b_cs_n(rom_b_cs_n)
);

// File: tb/pagemap_mmu_bench.sv
module pagemap_mmu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        port_wr = 1'b0;
  logic        mem_req = 1'b0;
  logic [17:0] phys_addr;
  logic        ram_ce, rom_a_cs_n, rom_b_cs_n;

  int checks = 0;
  int failures = 0;

  logic [3:0] m_tbl [4];
  logic       m_boot = 1'b1;
  logic       m_flag = 1'b1;

  always #4 clk = ~clk;

  pagemap_mmu u_pagemap_mmu (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .port_wr(port_wr), .mem_req(mem_req), .phys_addr(phys_addr),
    .ram_ce(ram_ce), .rom_a_cs_n(rom_a_cs_n), .rom_b_cs_n(rom_b_cs_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    cpu_wdata = b;
    port_wr   = 1'b1;
    @(negedge clk);
    port_wr   = 1'b0;
    cpu_wdata = 8'h00;
    m_tbl[b[5:4]] = b[3:0];
    m_boot = b[7];
    m_flag = b[6];
  endtask

  function automatic logic [17:0] exp_addr(input logic [15:0] a);
    logic [3:0] hi;
    hi = m_boot ? 4'hF : m_tbl[a[15:14]];
    return {hi, a[13:0]};
  endfunction

  task automatic chk_page(input string req, input logic [1:0] pg, input logic [13:0] ofs);
    cpu_addr = {pg, ofs};
    #1;
    check(req, 32'(phys_addr), 32'(exp_addr(cpu_addr)));
  endtask

  task automatic chk_selects(input string req, input logic [1:0] pg, input logic rq);
    logic [17:0] e;
    cpu_addr = {pg, 14'h0123};
    mem_req  = rq;
    #1;
    e = exp_addr(cpu_addr);
    check(req, {29'd0, ram_ce, rom_a_cs_n, rom_b_cs_n},
          {29'd0, rq & ~e[17], ~(rq & e[17] & m_flag), ~(rq & e[17] & ~m_flag)});
    mem_req = 1'b0;
  endtask

  task automatic t_reset;
    for (int p = 0; p < 4; p++) chk_page("R1", 2'(p), 14'h2A5 + 14'(p));
    chk_page("R1", 2'd3, 14'h3FFF);
    check("R1", 32'(phys_addr), 32'h3FFFF);
    chk_selects("R8", 2'd0, 1'b1);
  endtask

  task automatic t_boot_fill;
    wr(8'hC0);
    wr(8'hD9);
    wr(8'hEA);
    for (int p = 0; p < 4; p++) chk_page("R2", 2'(p), 14'h0040);
    wr(8'h7B);
    for (int p = 0; p < 4; p++) chk_page("R3", 2'(p), 14'h1111 + 14'(p));
    chk_page("R4", 2'd2, 14'h3FFF);
    check("R4", 32'(phys_addr), 32'h2BFFF);
  endtask

  task automatic t_no_strobe;
    cpu_wdata = 8'hA5;
    repeat (3) @(negedge clk);
    cpu_wdata = 8'h00;
    for (int p = 0; p < 4; p++) chk_page("R5", 2'(p), 14'h0777);
    chk_selects("R5", 2'd1, 1'b1);
  endtask

  task automatic t_single_entry;
    wr(8'h65);
    for (int p = 0; p < 4; p++) chk_page("R10", 2'(p), 14'h0300);
  endtask

  task automatic t_selects;
    chk_selects("R7", 2'd0, 1'b1);
    chk_selects("R7", 2'd0, 1'b0);
    chk_selects("R8", 2'd1, 1'b1);
    wr(8'h19);
    chk_selects("R8", 2'd1, 1'b1);
    chk_selects("R8", 2'd1, 1'b0);
    chk_selects("R7", 2'd2, 1'b1);
  endtask

  task automatic t_reenter_boot;
    wr(8'hC4);
    for (int p = 0; p < 4; p++) chk_page("R6", 2'(p), 14'h0010);
    wr(8'h7B);
    chk_page("R2", 2'd0, 14'h0010);
    check("R2", 32'(phys_addr[17:14]), 32'h4);
  endtask

  task automatic t_async_reset;
    wr(8'h19);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    m_boot = 1'b1;
    m_flag = 1'b1;
    chk_page("R9", 2'd1, 14'h0055);
    chk_selects("R9", 2'd1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot_fill();
    t_no_strobe();
    t_single_entry();
    t_selects();
    t_reenter_boot();
    t_async_reset();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule